// File: doc/BRIEF.md
# Smart-Card UART Status and Interrupt Register

This block holds the status byte that a host microcontroller reads to learn what the smart-card UART and its three time-out counters have done. Seven of its bits are sticky event flags: three time-out flags, an early-answer flag, a parity-error flag, an overrun flag and a framing-error flag. The eighth bit is a buffer flag. It means "transmit side empty" or "receive side full", and it follows the data traffic instead of the status reads. The serial engine, the counters and the FIFO sit outside the block. Each of them reports to it through a single-cycle event pulse.

The host reads the byte at address 0xE with an active-low read strobe. The byte it sees is the state before any clear. When the strobe rises at the end of that read, every sticky flag that was visible during the read is cleared a programmable number of cycles later. The buffer flag is cleared a fixed number of cycles after a write to the transmit data register or a read of the receive data register. It is also cleared when the UART leaves transmit mode for receive mode. An active-low interrupt output is driven low while any sticky flag is set. It is also driven low while the buffer flag is set and that flag's mask input is 0.

All pins are plain control and status signals. None of them carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `card_uart_stat`

## Requirements
- R1: After reset all eight status bits are 0 and `irq_n` is 1.
- R2: Each event sets one status bit, from MSB to LSB: bit 7 time-out 3 (`evt_pulse[6]`), bit 6 time-out 2 (`evt_pulse[5]`), bit 5 time-out 1 (`evt_pulse[4]`), bit 4 early answer (`evt_pulse[3]`), bit 3 parity error (`evt_pulse[2]`), bit 2 overrun (`evt_pulse[1]`), bit 1 framing error (`evt_pulse[0]`), bit 0 buffer flag. `bus_rdata` shows the byte while `bus_rd_n` is 0 and `bus_addr` is 0xE. Otherwise `bus_rdata` is 0x00.
- R3: While any of bits 7..1 is set, `irq_n` is 0.
- R4: Bits 7..1 that were set during a read at 0xE are cleared at the CLR_DLY-th clock edge after the first edge that samples the read as ended (default CLR_DLY = 2). A read at any other address clears nothing.
- R5: A sticky event in the same cycle as that bit's clear wins, and the bit stays set.
- R6: During a read, `bus_rdata` shows the flags that caused the interrupt, before any clear takes effect.
- R7: The buffer flag is set by `rx_full_p`, or by `tx_done_p` while `last_char_mode` is 0. While the flag is set, it drives `irq_n` to 0 only if `buf_irq_mask` is 0.
- R8: A pulse on `tx_data_wr_p` or `rx_data_rd_p` clears the buffer flag at the third clock edge after the edge that samples the pulse (BUF_DLY = 3).
- R9: A change of `tx_mode` from 1 to 0 clears the buffer flag at the edge that samples the change.
- R10: `tx_done_p` while `last_char_mode` is 1 leaves the buffer flag at 0.
- R11: A status read does not clear the buffer flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| bus_addr | input | 4 | Host register address |
| bus_rd_n | input | 1 | Active-low host read strobe |
| bus_rdata | output | 8 | Status byte during a read at 0xE, 0x00 otherwise |
| evt_pulse | input | 7 | Sticky event pulses: [6] TO3, [5] TO2, [4] TO1, [3] early answer, [2] parity, [1] overrun, [0] framing |
| rx_full_p | input | 1 | Receive side became full |
| tx_done_p | input | 1 | Transmission of a character finished |
| last_char_mode | input | 1 | The current character is sent as the last one |
| tx_data_wr_p | input | 1 | Host wrote the transmit data register |
| rx_data_rd_p | input | 1 | Host read the receive data register |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| buf_irq_mask | input | 1 | 1 keeps the buffer flag off the interrupt |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can meet in one cycle. The delayed clear that follows a status read can land on the same edge as a fresh pulse for the same bit. The bench provokes this by counting the edges after it raises the read strobe and driving the time-out 1 pulse so that the clear edge samples it. It then judges the outcome by `irq_n` staying low and by a later read that still shows bit 5. The exact clear edge of both delays is also pinned down by sampling `irq_n` one cycle before and one cycle after the expected edge.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int STAT_W     = 8;
  localparam int NUM_STICKY = STAT_W - 1;
  localparam int ADDR_W     = 4;

  typedef logic [NUM_STICKY-1:0] sticky_t;
  typedef logic [STAT_W-1:0]     stat_byte_t;

  localparam logic [ADDR_W-1:0] STAT_ADDR_DEF = 4'hE;
endpackage

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank
  import card_stat_pkg::*;
#(
  parameter int N = NUM_STICKY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        flags_o[b] <= 1'b0;
      else if (set_i[b]) flags_o[b] <= 1'b1;
      else if (clr_i[b]) flags_o[b] <= 1'b0;
    end

    // R5
    sticky_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> flags_o[b]);

    // R4
    sticky_fall_by_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_o[b]) |-> $past(clr_i[b]));
  end

endmodule

// File: rtl/stat_read_clear.sv
module stat_read_clear
  import card_stat_pkg::*;
#(
  parameter int                CLR_DLY   = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = STAT_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_n,
  input  sticky_t           flags_now,
  output logic              rd_sel_o,
  output sticky_t           clr_mask_o
);

  localparam int CW = $clog2(CLR_DLY + 1);

  logic    sel_q;
  logic    pend_q;
  logic [CW-1:0] cnt_q;
  sticky_t snap_q;
  sticky_t mask_q;
  logic    rd_end;
  logic    fire;

  assign rd_sel_o   = !bus_rd_n && (bus_addr == STAT_ADDR);
  assign rd_end     = sel_q && !rd_sel_o;
  assign fire       = pend_q && (cnt_q == CW'(1));
  assign clr_mask_o = fire ? mask_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      sel_q <= rd_sel_o;
      if (rd_sel_o) snap_q <= sel_q ? (snap_q | flags_now) : flags_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (rd_end) begin
      pend_q <= 1'b1;
      cnt_q  <= CW'(CLR_DLY);
      mask_q <= pend_q ? (mask_q | snap_q) : snap_q;
    end else if (pend_q) begin
      if (fire) begin
        pend_q <= 1'b0;
        mask_q <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  // R4
  clr_only_set_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask_o != '0) |-> ((clr_mask_o & ~flags_now) == '0));

endmodule

// File: rtl/stat_buf_flag.sv
module stat_buf_flag #(
  parameter int BUF_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_full_p,
  input  logic tx_done_p,
  input  logic last_char_mode,
  input  logic tx_data_wr_p,
  input  logic rx_data_rd_p,
  input  logic tx_mode,
  output logic flag_o
);

  logic [BUF_DLY-1:0] dly_q;
  logic               mode_q;
  logic               acc;
  logic               set_now;
  logic               mode_fall;
  logic               clr_now;

  assign acc       = tx_data_wr_p | rx_data_rd_p;
  assign set_now   = rx_full_p | (tx_done_p & ~last_char_mode);
  assign mode_fall = mode_q & ~tx_mode;
  assign clr_now   = dly_q[BUF_DLY-1] | mode_fall;

  if (BUF_DLY == 1) begin : g_dly1
    always_ff @(posedge clk) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= acc;
    end
  end else begin : g_dlyn
    always_ff @(posedge clk) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= {dly_q[BUF_DLY-2:0], acc};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      mode_q <= tx_mode;
      if (set_now)      flag_o <= 1'b1;
      else if (clr_now) flag_o <= 1'b0;
    end
  end

  // R9
  mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !tx_mode && !rx_full_p && !tx_done_p) |=> !flag_o);

  // R10
  last_char_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_p && last_char_mode && !rx_full_p && !flag_o) |=> !flag_o);

  // R7
  rx_full_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_p |=> flag_o);

endmodule

// File: rtl/card_uart_stat.sv
module card_uart_stat
  import card_stat_pkg::*;
#(
  parameter int                CLR_DLY   = 2,
  parameter int                BUF_DLY   = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = STAT_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_n,
  output logic [STAT_W-1:0] bus_rdata,
  input  logic [NUM_STICKY-1:0] evt_pulse,
  input  logic              rx_full_p,
  input  logic              tx_done_p,
  input  logic              last_char_mode,
  input  logic              tx_data_wr_p,
  input  logic              rx_data_rd_p,
  input  logic              tx_mode,
  input  logic              buf_irq_mask,
  output logic              irq_n
);

  sticky_t sticky;
  sticky_t clr_mask;
  logic    rd_sel;
  logic    buf_flag;

  stat_read_clear #(.CLR_DLY(CLR_DLY), .STAT_ADDR(STAT_ADDR)) u_rdclr (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd_n   (bus_rd_n),
    .flags_now  (sticky),
    .rd_sel_o   (rd_sel),
    .clr_mask_o (clr_mask)
  );

  stat_sticky_bank #(.N(NUM_STICKY)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_pulse),
    .clr_i   (clr_mask),
    .flags_o (sticky)
  );

  stat_buf_flag #(.BUF_DLY(BUF_DLY)) u_buf (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_full_p      (rx_full_p),
    .tx_done_p      (tx_done_p),
    .last_char_mode (last_char_mode),
    .tx_data_wr_p   (tx_data_wr_p),
    .rx_data_rd_p   (rx_data_rd_p),
    .tx_mode        (tx_mode),
    .flag_o         (buf_flag)
  );

  assign bus_rdata = rd_sel ? {sticky, buf_flag} : '0;
  assign irq_n     = !((|sticky) || (buf_flag && !buf_irq_mask));

  // R11
  read_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_flag && !tx_data_wr_p && !rx_data_rd_p && tx_mode) |=> buf_flag);

endmodule

// File: tb/card_uart_stat_tb_top.sv
module card_uart_stat_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_rd_n = 1'b1;
  logic [7:0] bus_rdata;
  logic [6:0] evt_pulse = '0;
  logic       rx_full_p = 1'b0, tx_done_p = 1'b0, last_char_mode = 1'b0;
  logic       tx_data_wr_p = 1'b0, rx_data_rd_p = 1'b0, tx_mode = 1'b0;
  logic       buf_irq_mask = 1'b0;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_uart_stat dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .rx_full_p(rx_full_p),
    .tx_done_p(tx_done_p), .last_char_mode(last_char_mode),
    .tx_data_wr_p(tx_data_wr_p), .rx_data_rd_p(rx_data_rd_p),
    .tx_mode(tx_mode), .buf_irq_mask(buf_irq_mask), .irq_n(irq_n)
  );

  // {evt[6:0], rx_full, tx_done, last_char, mask, expected byte, expected irq_n}
  localparam logic [19:0] VECS [12] = '{
    {7'b0000001, 4'b0000, 8'h02, 1'b0},
    {7'b0000010, 4'b0000, 8'h04, 1'b0},
    {7'b0000100, 4'b0000, 8'h08, 1'b0},
    {7'b0001000, 4'b0000, 8'h10, 1'b0},
    {7'b0010000, 4'b0000, 8'h20, 1'b0},
    {7'b0100000, 4'b0000, 8'h40, 1'b0},
    {7'b1000000, 4'b0000, 8'h80, 1'b0},
    {7'b0000000, 4'b1000, 8'h01, 1'b0},
    {7'b0000000, 4'b1001, 8'h01, 1'b1},
    {7'b0000000, 4'b0100, 8'h01, 1'b0},
    {7'b0000000, 4'b0110, 8'h00, 1'b1},
    {7'b1010101, 4'b1001, 8'hAB, 1'b0}
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_stat(input logic [3:0] a, output logic [7:0] val);
    bus_addr = a;
    bus_rd_n = 1'b0;
    tick();
    val = bus_rdata;
    bus_rd_n = 1'b1;
    tick(5);
  endtask

  task automatic clear_buf();
    rx_data_rd_p = 1'b1;
    tick();
    rx_data_rd_p = 1'b0;
    tick(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    tick(3);
    // R1 reset state
    bus_addr = 4'hE; bus_rd_n = 1'b0;
    tick();
    check(bus_rdata == 8'h00, "R1 reset byte", bus_rdata, 0);
    check(irq_n == 1'b1, "R1 reset irq_n", irq_n, 1);
    bus_rd_n = 1'b1;
    rst_n = 1'b1;
    tick(2);
    check(irq_n == 1'b1, "R1 after reset irq_n", irq_n, 1);

    // Table walk: R2 R3 R7 R10 R11
    for (int i = 0; i < 12; i++) begin
      logic [19:0] v;
      v = VECS[i];
      buf_irq_mask = v[9];
      last_char_mode = v[10];
      evt_pulse = v[19:13];
      rx_full_p = v[12];
      tx_done_p = v[11];
      tick();
      evt_pulse = '0; rx_full_p = 1'b0; tx_done_p = 1'b0;
      check(irq_n == v[0], "R3/R7 irq_n", irq_n, v[0]);
      read_stat(4'hE, rv);
      check(rv == v[8:1], "R2/R10 status byte", rv, v[8:1]);
      read_stat(4'hE, rv);
      check(rv == (v[8:1] & 8'h01), "R4/R11 byte after read", rv, v[8:1] & 8'h01);
      last_char_mode = 1'b0;
      clear_buf();
      buf_irq_mask = 1'b0;
    end

    // R2/R4 read at another address: no data, no clear
    evt_pulse = 7'b0000001; tick(); evt_pulse = '0;
    read_stat(4'h5, rv);
    check(rv == 8'h00, "R2 other address byte", rv, 0);
    check(irq_n == 1'b0, "R4 other address no clear", irq_n, 0);
    read_stat(4'hE, rv);
    check(rv == 8'h02, "R4 flag kept after foreign read", rv, 8'h02);
    check(irq_n == 1'b1, "R4 cleared after status read", irq_n, 1);

    // R4/R6 exact clear edge
    evt_pulse = 7'b0010000; tick(); evt_pulse = '0;
    bus_addr = 4'hE; bus_rd_n = 1'b0;
    tick();
    check(bus_rdata == 8'h20, "R6 byte before clear", bus_rdata, 8'h20);
    bus_rd_n = 1'b1;
    tick();
    check(irq_n == 1'b0, "R4 one edge after end", irq_n, 0);
    tick();
    check(irq_n == 1'b0, "R4 edge before clear", irq_n, 0);
    tick();
    check(irq_n == 1'b1, "R4 clear edge", irq_n, 1);
    tick(3);

    // R5 event on the clear edge wins
    evt_pulse = 7'b0010000; tick(); evt_pulse = '0;
    bus_addr = 4'hE; bus_rd_n = 1'b0;
    tick();
    bus_rd_n = 1'b1;
    tick(2);
    evt_pulse = 7'b0010000;
    tick();
    evt_pulse = '0;
    check(irq_n == 1'b0, "R5 set wins irq_n", irq_n, 0);
    read_stat(4'hE, rv);
    check(rv == 8'h20, "R5 set wins byte", rv, 8'h20);
    check(irq_n == 1'b1, "R5 later read clears", irq_n, 1);

    // R8 buffer clear timing
    rx_full_p = 1'b1; tick(); rx_full_p = 1'b0;
    rx_data_rd_p = 1'b1;
    tick();
    rx_data_rd_p = 1'b0;
    check(irq_n == 1'b0, "R8 after 1 edge", irq_n, 0);
    tick();
    check(irq_n == 1'b0, "R8 after 2 edges", irq_n, 0);
    tick();
    check(irq_n == 1'b0, "R8 after 3 edges", irq_n, 0);
    tick();
    check(irq_n == 1'b1, "R8 after 4 edges", irq_n, 1);

    // R8 via transmit write
    rx_full_p = 1'b1; tick(); rx_full_p = 1'b0;
    tx_data_wr_p = 1'b1; tick(); tx_data_wr_p = 1'b0;
    tick(4);
    check(irq_n == 1'b1, "R8 transmit write clears", irq_n, 1);

    // R9 mode change
    tx_mode = 1'b1; tick(2);
    tx_done_p = 1'b1; tick(); tx_done_p = 1'b0;
    check(irq_n == 1'b0, "R7 tx done sets", irq_n, 0);
    tick(2);
    tx_mode = 1'b0;
    tick();
    check(irq_n == 1'b1, "R9 mode change clears", irq_n, 1);
    read_stat(4'hE, rv);
    check(rv == 8'h00, "R9 byte after mode change", rv, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule